// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block moves one descriptor's worth of data on a single DMA channel. A host-side sequencer presents a packed 32-bit configuration word, a source address, a destination address and a byte length, then pulses `start_i`. The engine then reads from the source and writes to the destination over one shared memory-style master port. The transfer runs in rounds. Each round reads one source burst into a 32-byte staging buffer and then drains those bytes to the destination. Either side can be an incrementing memory region or a fixed peripheral register. A peripheral side is paced by one of 32 request lines.

The configuration word holds two copies of the same field set. The source fields sit in bits [10:0] and the destination fields sit in bits [26:16]. Each set has a request number, an addressing mode, a burst code and a width code. The live source address, destination address, remaining byte count and configuration are always visible on readback ports. A pause level holds the engine at the next source-burst boundary. The engine ends with a one-cycle `done_o`, and `err_o` reports a rejected configuration.

The control state machine has seven states:
- IDLE waits for start.
- CHECK validates the codes.
- RD_WAIT waits for pause release and source request.
- RD_BEAT issues read beats.
- WR_WAIT waits for destination request.
- WR_BEAT issues write beats.
- FINISH pulses done.

The transitions are:
- IDLE→CHECK on start.
- CHECK→FINISH on a bad code or zero length.
- CHECK→RD_WAIT otherwise.
- RD_WAIT→RD_BEAT when unpaused and the source is ready.
- RD_BEAT→WR_WAIT on the last read of the round.
- WR_WAIT→WR_BEAT when the destination is ready.
- WR_BEAT→RD_WAIT on the last write of a round with bytes left.
- WR_BEAT→FINISH on the last write of the final round.
- FINISH→IDLE.

Top module: `dma_xfer_engine`

## Requirements
- R1: A `start_i` pulse seen in IDLE loads `cfg_i`, `src_i`, `dst_i` and `len_i`. One cycle later `busy_o` is 1, and `cur_cfg_o`, `cur_src_o`, `cur_dst_o` and `cur_cnt_o` show the loaded values.
- R2: Each side's width code sets the bytes per beat: source bits [10:9] and destination bits [26:25], where 0→1, 1→2 and 2→4 bytes. The code is driven on `bus_size_o` during that side's beats. Read data is taken from the low byte lanes, and write data is placed in the low lanes with the unused upper lanes zero.
- R3: On an incrementing side (source bit 5 or destination bit 21 clear), the address advances by the beat width after every accepted beat. On a fixed side (bit set), the address never changes.
- R4: A round moves `min(remaining, beats × width_src)` bytes, where the source burst code in bits [8:7] is 0→1 beat or 2→8 beats. The round issues ceil(round/width_src) reads and then ceil(round/width_dst) writes, and bytes reach the destination in the order they were read.
- R5: `cur_cnt_o` drops by the round size only when the round's last write is accepted, so it moves at burst granularity and never increases during a transfer.
- R6: A fixed side starts its burst only while `drq_i[req]` is 1. The request number is source bits [4:0] or destination bits [20:16], and request number 1 is always ready. An incrementing side never waits on a request line.
- R7: While `pause_i` is 1, no new source burst starts. The current round completes, and the engine then holds with no bus activity until `pause_i` returns to 0.
- R8: A burst code of 1 or 3, or a width code of 3, on either side ends the transfer at once. `done_o` pulses, `err_o` is 1, and no bus beat is issued. `err_o` holds until the next accepted start.
- R9: `done_o` is a single-cycle pulse given when the count reaches zero, with `cur_cnt_o` equal to 0. A zero length gives `done_o` with no bus beats, and `busy_o` falls the cycle after `done_o`.
- R10: A `start_i` pulse while `busy_o` is 1 is ignored. The running transfer and its readback values are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a transfer (sampled in IDLE) |
| cfg_i | input | 32 | Packed side configuration |
| src_i | input | AW | Source start address |
| dst_i | input | AW | Destination start address |
| len_i | input | LEN_W | Byte length |
| pause_i | input | 1 | Hold at next source-burst boundary |
| drq_i | input | 2**REQ_BITS | Peripheral request lines |
| bus_valid_o | output | 1 | Beat request |
| bus_write_o | output | 1 | 1 = write beat, 0 = read beat |
| bus_addr_o | output | AW | Beat address |
| bus_size_o | output | 2 | Width code of the beat |
| bus_wdata_o | output | 32 | Write data, low lanes |
| bus_ready_i | input | 1 | Beat accepted this cycle |
| bus_rdata_i | input | 32 | Read data, valid with ready on a read |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | End-of-transfer pulse |
| err_o | output | 1 | Configuration rejected |
| cur_src_o | output | AW | Live source address |
| cur_dst_o | output | AW | Live destination address |
| cur_cnt_o | output | LEN_W | Remaining bytes |
| cur_cfg_o | output | 32 | Active configuration |

## Verification
The main function is tried with four input patterns, each separating a different mechanism:
- Memory-to-memory transfers with equal widths and 8-beat bursts over two rounds. These tell correct round splitting and address stepping apart from off-by-one round ends.
- A 1-byte source with a 4-byte destination. This separates byte-lane packing and beat counts per side from a design that simply mirrors reads into writes.
- A fixed source gated by a request line, and a fixed destination on request number 1. These distinguish request gating from the memory exemption and show that fixed addresses hold still.
- A transfer paused before it starts and again mid-way, plus bad-code, zero-length and start-while-busy cases. These separate burst-boundary pausing, the error path and start filtering from the normal flow.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

    localparam int CFG_W = 32;

    typedef enum logic [2:0] {
        S_IDLE, S_CHECK, S_RD_WAIT, S_RD_BEAT, S_WR_WAIT, S_WR_BEAT, S_FINISH
    } xfer_state_e;

    typedef struct packed {
        logic [4:0] req;
        logic       fixed;
        logic [1:0] burst;
        logic [1:0] width;
    } side_cfg_t;

    // hi = 0 selects the source half, hi = 1 the destination half
    function automatic side_cfg_t side_of(input logic [CFG_W-1:0] c, input logic hi);
        logic [CFG_W-1:0] s;
        s = hi ? (c >> 16) : c;
        side_of.req   = s[4:0];
        side_of.fixed = s[5];
        side_of.burst = s[8:7];
        side_of.width = s[10:9];
    endfunction

    function automatic logic [2:0] width_bytes(input logic [1:0] w);
        case (w)
            2'd0:    width_bytes = 3'd1;
            2'd1:    width_bytes = 3'd2;
            default: width_bytes = 3'd4;
        endcase
    endfunction

    function automatic logic [6:0] burst_bytes(input side_cfg_t s);
        logic [3:0] beats;
        beats = (s.burst == 2'd2) ? 4'd8 : 4'd1;
        burst_bytes = 7'(beats) * 7'(width_bytes(s.width));
    endfunction

    function automatic logic code_bad(input side_cfg_t s);
        code_bad = (s.burst != 2'd0 && s.burst != 2'd2) || (s.width == 2'd3);
    endfunction

endpackage

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          step,
    input  logic          fixed,
    input  logic [2:0]    step_bytes,
    output logic [AW-1:0] addr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr <= '0;
        else if (load)
            addr <= load_addr;
        else if (step && !fixed)
            addr <= addr + AW'(step_bytes);
    end

    // R3
    fixed_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fixed && !load) |=> $stable(addr));

endmodule

// File: rtl/dma_byte_stage.sv
module dma_byte_stage #(
    parameter int DEPTH = 32
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_pos,
    input  logic [2:0]               wr_bytes,
    input  logic [31:0]              wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_pos,
    input  logic [2:0]               rd_bytes,
    output logic [31:0]              rd_data
);

    localparam int PW = $clog2(DEPTH);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int b = 0; b < DEPTH; b++) begin
            if (wr_en && (PW'(PW'(b) - wr_pos) < PW'(wr_bytes)))
                mem[b] <= 8'(wr_data >> {PW'(PW'(b) - wr_pos), 3'b000});
        end
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < 4; k++) begin
            if (3'(k) < rd_bytes)
                rd_data[8*k +: 8] = mem[PW'(rd_pos + PW'(k))];
        end
    end

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
    import dma_xfer_pkg::*;
#(
    parameter int AW          = 32,
    parameter int LEN_W       = 32,
    parameter int REQ_BITS    = 5,
    parameter int STAGE_BYTES = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [CFG_W-1:0]       cfg_i,
    input  logic [AW-1:0]          src_i,
    input  logic [AW-1:0]          dst_i,
    input  logic [LEN_W-1:0]       len_i,
    input  logic                   pause_i,
    input  logic [(1<<REQ_BITS)-1:0] drq_i,
    output logic                   bus_valid_o,
    output logic                   bus_write_o,
    output logic [AW-1:0]          bus_addr_o,
    output logic [1:0]             bus_size_o,
    output logic [31:0]            bus_wdata_o,
    input  logic                   bus_ready_i,
    input  logic [31:0]            bus_rdata_i,
    output logic                   busy_o,
    output logic                   done_o,
    output logic                   err_o,
    output logic [AW-1:0]          cur_src_o,
    output logic [AW-1:0]          cur_dst_o,
    output logic [LEN_W-1:0]       cur_cnt_o,
    output logic [CFG_W-1:0]       cur_cfg_o
);

    localparam int PW = $clog2(STAGE_BYTES);
    localparam int CW = PW + 2;

    xfer_state_e      state, state_nx;
    logic [CFG_W-1:0] cfg_q;
    logic [LEN_W-1:0] cnt_q;
    logic [CW-1:0]    chunk_q, rd_done, wr_done, chunk_nx;
    logic             err_q;

    side_cfg_t  sd [2];
    logic [2:0] wbytes [2];
    logic       side_rdy [2];
    logic [AW-1:0] side_addr [2];
    logic       hs, rd_last, wr_last, cfg_bad, load;
    logic [31:0] stage_out;

    assign sd[0] = side_of(cfg_q, 1'b0);
    assign sd[1] = side_of(cfg_q, 1'b1);
    assign cfg_bad = code_bad(sd[0]) || code_bad(sd[1]);
    assign hs      = bus_valid_o && bus_ready_i;
    assign load    = (state == S_IDLE) && start_i;
    assign rd_last = (rd_done + CW'(wbytes[0])) >= chunk_q;
    assign wr_last = (wr_done + CW'(wbytes[1])) >= chunk_q;
    assign chunk_nx = (cnt_q < LEN_W'(burst_bytes(sd[0]))) ? CW'(cnt_q)
                                                            : CW'(burst_bytes(sd[0]));

    for (genvar g = 0; g < 2; g++) begin : g_side
        assign wbytes[g]   = width_bytes(sd[g].width);
        assign side_rdy[g] = !sd[g].fixed || (sd[g].req == 5'd1) ||
                             drq_i[sd[g].req];
        dma_addr_gen #(.AW(AW)) u_addr (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (load),
            .load_addr ((g == 0) ? src_i : dst_i),
            .step      (hs && (bus_write_o == (g == 1))),
            .fixed     (sd[g].fixed),
            .step_bytes(wbytes[g]),
            .addr      (side_addr[g])
        );
    end

    dma_byte_stage #(.DEPTH(STAGE_BYTES)) u_stage (
        .clk     (clk),
        .wr_en   (state == S_RD_BEAT && hs),
        .wr_pos  (rd_done[PW-1:0]),
        .wr_bytes(wbytes[0]),
        .wr_data (bus_rdata_i),
        .rd_pos  (wr_done[PW-1:0]),
        .rd_bytes(wbytes[1]),
        .rd_data (stage_out)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (start_i) state_nx = S_CHECK;
            S_CHECK:   state_nx = (cfg_bad || cnt_q == '0) ? S_FINISH : S_RD_WAIT;
            S_RD_WAIT: if (!pause_i && side_rdy[0]) state_nx = S_RD_BEAT;
            S_RD_BEAT: if (hs && rd_last) state_nx = S_WR_WAIT;
            S_WR_WAIT: if (side_rdy[1]) state_nx = S_WR_BEAT;
            S_WR_BEAT: if (hs && wr_last)
                           state_nx = (cnt_q == LEN_W'(chunk_q)) ? S_FINISH : S_RD_WAIT;
            S_FINISH:  state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0; cnt_q <= '0; err_q <= 1'b0;
            chunk_q <= '0; rd_done <= '0; wr_done <= '0;
        end else begin
            if (load) begin
                cfg_q <= cfg_i;
                cnt_q <= len_i;
                err_q <= 1'b0;
            end
            if (state == S_CHECK && cfg_bad) err_q <= 1'b1;
            if (state == S_RD_WAIT && state_nx == S_RD_BEAT) begin
                chunk_q <= chunk_nx;
                rd_done <= '0;
                wr_done <= '0;
            end
            if (state == S_RD_BEAT && hs) rd_done <= rd_done + CW'(wbytes[0]);
            if (state == S_WR_BEAT && hs) begin
                wr_done <= wr_done + CW'(wbytes[1]);
                if (wr_last) cnt_q <= cnt_q - LEN_W'(chunk_q);
            end
        end
    end

    // outputs
    always_comb begin
        bus_valid_o = (state == S_RD_BEAT) || (state == S_WR_BEAT);
        bus_write_o = (state == S_WR_BEAT);
        bus_addr_o  = bus_write_o ? side_addr[1] : side_addr[0];
        bus_size_o  = bus_write_o ? sd[1].width : sd[0].width;
        bus_wdata_o = bus_write_o ? stage_out : '0;
        busy_o      = (state != S_IDLE);
        done_o      = (state == S_FINISH);
        err_o       = err_q;
        cur_src_o   = side_addr[0];
        cur_dst_o   = side_addr[1];
        cur_cnt_o   = cnt_q;
        cur_cfg_o   = cfg_q;
    end

    // R8
    bad_cfg_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid_o |-> !cfg_bad);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5
    cnt_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> (cur_cnt_o <= $past(cur_cnt_o)));

    // R7
    pause_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_valid_o) && !bus_write_o) |-> !$past(pause_i));

    // R10
    busy_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(cur_cfg_o));

endmodule

// File: tb/dma_xfer_engine_bench.sv
`timescale 1ns/1ps
module dma_xfer_engine_bench;

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [1:0]  size;
        logic [31:0] data;
    } beat_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] cfg_i = '0, src_i = '0, dst_i = '0, len_i = '0;
    logic        pause_i = 1'b0;
    logic [31:0] drq_i = '0;
    logic        bus_valid_o, bus_write_o;
    logic [31:0] bus_addr_o, bus_wdata_o, bus_rdata_i;
    logic [1:0]  bus_size_o;
    logic        bus_ready_i = 1'b1;
    logic        busy_o, done_o, err_o;
    logic [31:0] cur_src_o, cur_dst_o, cur_cnt_o, cur_cfg_o;

    int tests = 0, fails = 0, nbeats = 0;
    beat_t exp_q[$];
    logic [31:0] exp_src_end, exp_dst_end;

    always #2.5 clk = ~clk;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[7:0] + 8'd3, a[7:0] ^ 8'h5A, a[7:0] + 8'd17, ~a[7:0]};
    endfunction
    assign bus_rdata_i = mem_word(bus_addr_o);

    dma_xfer_engine u_dma_xfer_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_i(cfg_i),
        .src_i(src_i), .dst_i(dst_i), .len_i(len_i), .pause_i(pause_i),
        .drq_i(drq_i), .bus_valid_o(bus_valid_o), .bus_write_o(bus_write_o),
        .bus_addr_o(bus_addr_o), .bus_size_o(bus_size_o),
        .bus_wdata_o(bus_wdata_o), .bus_ready_i(bus_ready_i),
        .bus_rdata_i(bus_rdata_i), .busy_o(busy_o), .done_o(done_o),
        .err_o(err_o), .cur_src_o(cur_src_o), .cur_dst_o(cur_dst_o),
        .cur_cnt_o(cur_cnt_o), .cur_cfg_o(cur_cfg_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: pops expected beats as the design completes them (R2 R3 R4)
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && bus_valid_o && bus_ready_i) begin
                nbeats++;
                if (exp_q.size() == 0) begin
                    chk("R4 unexpected beat", {bus_write_o, bus_addr_o}, 64'h0);
                end else begin
                    beat_t e;
                    e = exp_q.pop_front();
                    chk("R2 R3 R4 beat", {bus_write_o, bus_size_o, bus_addr_o},
                        {e.we, e.size, e.addr});
                    if (e.we) chk("R2 R4 wdata", bus_wdata_o, e.data);
                end
            end
        end
    end

    // ready pattern: stall one cycle in three
    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            bus_ready_i = (cyc % 3) != 2;
        end
    end

    function automatic logic [31:0] mk(input int sreq, input bit sfix, input int sb,
                                       input int sw, input int dreq, input bit dfix,
                                       input int db, input int dw);
        logic [31:0] c = '0;
        c[4:0] = 5'(sreq); c[5] = sfix; c[8:7] = 2'(sb); c[10:9] = 2'(sw);
        c[20:16] = 5'(dreq); c[21] = dfix; c[24:23] = 2'(db); c[26:25] = 2'(dw);
        return c;
    endfunction

    // driver: expected beats from the requirements
    task automatic plan_xfer(input logic [31:0] c, input logic [31:0] s,
                             input logic [31:0] d, input int len);
        int sw = 1 << c[10:9];
        int dw = 1 << c[26:25];
        int sb = (c[8:7] == 2'd2) ? 8 : 1;
        int rem = len;
        logic [31:0] sa = s, da = d;
        while (rem > 0) begin
            int chunk = (rem < sb * sw) ? rem : sb * sw;
            logic [7:0] st[$];
            for (int r = 0; r < chunk; r += sw) begin
                logic [31:0] w = mem_word(sa);
                exp_q.push_back({1'b0, sa, c[10:9], 32'h0});
                for (int k = 0; k < sw; k++) st.push_back(w[8*k +: 8]);
                if (!c[5]) sa += 32'(sw);
            end
            for (int r = 0; r < chunk; r += dw) begin
                logic [31:0] w = '0;
                for (int k = 0; k < dw; k++) w[8*k +: 8] = st[r + k];
                exp_q.push_back({1'b1, da, c[26:25], w});
                if (!c[21]) da += 32'(dw);
            end
            rem -= chunk;
        end
        exp_src_end = sa;
        exp_dst_end = da;
    endtask

    task automatic kick(input logic [31:0] c, input logic [31:0] s,
                        input logic [31:0] d, input logic [31:0] len);
        @(negedge clk);
        cfg_i = c; src_i = s; dst_i = d; len_i = len; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done_o && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk({req, " done seen"}, done_o, 1'b1);
    endtask

    task automatic finish_checks(input string req, input bit exp_err);
        chk({req, " err"}, err_o, exp_err);
        chk({req, " count zero"}, cur_cnt_o, 0);
        chk({req, " queue drained"}, exp_q.size(), 0);
        @(negedge clk);
        chk("R9 done pulse width", done_o, 1'b0);
        chk("R9 busy falls", busy_o, 1'b0);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] c;
        int n0;
        logic [31:0] cnt0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("reset busy", busy_o, 0);
        chk("reset done", done_o, 0);
        chk("reset bus", bus_valid_o, 0);

        // mem to mem, 4-byte beats, 8-beat bursts, two rounds (R1 R4)
        c = mk(1, 0, 2, 2, 1, 0, 2, 2);
        plan_xfer(c, 32'h1000, 32'h2000, 64);
        kick(c, 32'h1000, 32'h2000, 64);
        chk("R1 busy", busy_o, 1);
        chk("R1 cfg readback", cur_cfg_o, c);
        chk("R1 cnt readback", cur_cnt_o, 64);
        chk("R1 src readback", cur_src_o, 32'h1000);
        chk("R1 dst readback", cur_dst_o, 32'h2000);
        wait_done("R9");
        chk("R3 src end", cur_src_o, exp_src_end);
        chk("R3 dst end", cur_dst_o, exp_dst_end);
        finish_checks("R4", 0);

        // 1-byte source, 4-byte destination (R2 R4)
        c = mk(1, 0, 2, 0, 1, 0, 0, 2);
        plan_xfer(c, 32'h3003, 32'h4000, 16);
        kick(c, 32'h3003, 32'h4000, 16);
        wait_done("R2");
        chk("R3 src end mixed", cur_src_o, exp_src_end);
        finish_checks("R2", 0);

        // fixed source gated by request 7 (R6 R3)
        drq_i = '0;
        c = mk(7, 1, 0, 2, 1, 0, 0, 2);
        plan_xfer(c, 32'h5000, 32'h6000, 12);
        n0 = nbeats;
        kick(c, 32'h5000, 32'h6000, 12);
        repeat (20) @(negedge clk);
        chk("R6 waits on request", nbeats, n0);
        chk("R6 count held", cur_cnt_o, 12);
        drq_i[7] = 1'b1;
        wait_done("R6");
        chk("R3 fixed src holds", cur_src_o, 32'h5000);
        finish_checks("R6", 0);
        drq_i = '0;

        // fixed destination on request 1, always ready (R6 R3)
        c = mk(1, 0, 2, 1, 1, 1, 2, 1);
        plan_xfer(c, 32'h7000, 32'h8000, 32);
        kick(c, 32'h7000, 32'h8000, 32);
        wait_done("R6");
        chk("R3 fixed dst holds", cur_dst_o, 32'h8000);
        finish_checks("R6", 0);

        // pause before start and mid-transfer (R7 R5)
        pause_i = 1'b1;
        c = mk(1, 0, 2, 2, 1, 0, 2, 2);
        plan_xfer(c, 32'h9000, 32'hA000, 64);
        n0 = nbeats;
        kick(c, 32'h9000, 32'hA000, 64);
        repeat (15) @(negedge clk);
        chk("R7 paused before first burst", nbeats, n0);
        chk("R7 count while paused", cur_cnt_o, 64);
        pause_i = 1'b0;
        while (nbeats == n0) @(negedge clk);
        pause_i = 1'b1;
        repeat (40) @(negedge clk);
        cnt0 = cur_cnt_o;
        n0 = nbeats;
        repeat (10) @(negedge clk);
        chk("R7 no beats while held", nbeats, n0);
        chk("R5 count at burst boundary", cnt0, 32);
        chk("R5 count stable", cur_cnt_o, cnt0);
        pause_i = 1'b0;
        wait_done("R7");
        finish_checks("R7", 0);

        // invalid burst code 1 on source (R8)
        c = mk(1, 0, 1, 2, 1, 0, 0, 2);
        n0 = nbeats;
        kick(c, 32'h100, 32'h200, 16);
        wait_done("R8");
        chk("R8 no beats bad burst", nbeats, n0);
        chk("R8 err bad burst", err_o, 1);
        @(negedge clk);
        chk("R8 err held", err_o, 1);

        // invalid width code 3 on destination (R8)
        c = mk(1, 0, 0, 2, 1, 0, 0, 3);
        kick(c, 32'h100, 32'h200, 16);
        wait_done("R8");
        chk("R8 no beats bad width", nbeats, n0);
        chk("R8 err bad width", err_o, 1);

        // zero length (R9), also clears err on start (R8)
        c = mk(1, 0, 0, 2, 1, 0, 0, 2);
        n0 = nbeats;
        kick(c, 32'h100, 32'h200, 0);
        chk("R8 err cleared by start", err_o, 0);
        wait_done("R9");
        chk("R9 zero length no beats", nbeats, n0);
        finish_checks("R9", 0);

        // start while busy is ignored (R10)
        c = mk(1, 0, 0, 2, 1, 0, 0, 2);
        plan_xfer(c, 32'hB000, 32'hC000, 32);
        kick(c, 32'hB000, 32'hC000, 32);
        repeat (5) @(negedge clk);
        kick(mk(1, 0, 3, 3, 1, 0, 3, 3), 32'h0, 32'h0, 99);
        chk("R10 cfg kept", cur_cfg_o, c);
        wait_done("R10");
        chk("R10 dst end", cur_dst_o, exp_dst_end);
        finish_checks("R10", 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule